// File: doc/BRIEF.md
# Edge-Triggered Wake Event Controller

This block watches a set of general-purpose event inputs on behalf of a power-management unit. Each input passes through a two-flop synchronizer and then an edge detector whose sensitivity is chosen per input. When an enabled input sees its chosen edge, it latches a sticky status bit and performs one configured action. The action can be a system-management interrupt, an alert interrupt toward the SMBus host, a wake pulse, a request to resume or a request to suspend. A resume or suspend request can also raise an interrupt.

The block tracks whether the system is awake or suspended. It sends one-cycle resume and suspend strobes to the power sequencer only when they would change that state. A wake-disable input blocks every wake-type action. The per-input enable, polarity and action registers and the status clear strobe arrive as ports from a register file outside this block.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After reset all status bits are 0. The interrupt, alert, wake, resume and suspend outputs are 0, and the power state reports suspended (`pwr_awake`=0).
- R2: An input change sampled at a rising clock edge shows up in the status and action outputs after the second rising edge that follows. It does not show up after the first of those two edges.
- R3: Polarity bit 1 selects a rising edge and 0 selects a falling edge. An edge of the opposite direction sets no status and triggers no action.
- R4: An input whose enable bit is 0 sets no status bit and triggers no action.
- R5: Status bits stay set until `clr_wr` is pulsed with a 1 in the matching `clr_mask` bit. A new event in the same cycle as its clear leaves the bit set.
- R6: The action code per input is 3 bits. The codes are 0 status only, 1 SMI, 2 alert, 3 wake pulse, 4 suspend, 5 resume, 6 resume with SMI and 7 suspend with SMI. `smi_evt` is the OR of enabled pending bits whose code is 1, 6 or 7. `alert_pull` is the OR of enabled pending bits whose code is 2.
- R7: An event with code 3 gives a one-cycle `wake_pulse`, unless `wake_dis` was 1 in the detecting cycle.
- R8: An event with code 5 or 6 while suspended, with `wake_dis` low, gives a one-cycle `resume_req` and sets `pwr_awake` to 1.
- R9: An event with code 4 or 7 while awake gives a one-cycle `suspend_req` and clears `pwr_awake`.
- R10: A resume event while awake, or a suspend event while suspended, produces no strobe and leaves `pwr_awake` unchanged.
- R11: An event with code 0 sets its status bit but drives no interrupt, wake or request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | N | Asynchronous event inputs |
| ev_en | input | N | Per-input enable |
| ev_rise | input | N | Per-input polarity, 1 rising, 0 falling |
| ev_act | input | 3*N | Per-input action code, input i in bits [3i+2:3i] |
| wake_dis | input | 1 | Blocks wake pulse and resume actions when high |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | N | Bits to clear when `clr_wr` is high |
| ev_status | output | N | Sticky event status |
| smi_evt | output | 1 | System-management interrupt event |
| alert_pull | output | 1 | High tells the pad to drive the active-low alert line low; low releases it |
| wake_pulse | output | 1 | One-cycle wake output |
| resume_req | output | 1 | One-cycle resume strobe to the sequencer |
| suspend_req | output | 1 | One-cycle suspend strobe to the sequencer |
| pwr_awake | output | 1 | Current power state, 1 awake |

## Verification
The bench builds the block with the default N=8. This lets eight inputs of mixed polarity, enable and action code all fire within a few cycles of each other. Resume and suspend events therefore collide in the same cycle, and each of them meets both power states. The random phase also toggles `wake_dis` and clears while edges are still in flight. This reaches the cases where a set and a clear of the same status bit fall in one cycle, and where configuration changes between sampling and detection.

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   ev_in,
  input  logic [N-1:0]   ev_en,
  input  logic [N-1:0]   ev_rise,
  input  logic [3*N-1:0] ev_act,
  input  logic           wake_dis,
  input  logic           clr_wr,
  input  logic [N-1:0]   clr_mask,
  output logic [N-1:0]   ev_status,
  output logic           smi_evt,
  output logic           alert_pull,
  output logic           wake_pulse,
  output logic           resume_req,
  output logic           suspend_req,
  output logic           pwr_awake
);
  localparam int AW = 3;
  localparam logic [AW-1:0] A_SMI = 3'd1, A_ALERT = 3'd2, A_WAKE = 3'd3,
                            A_SUSP = 3'd4, A_RES = 3'd5, A_RES_I = 3'd6, A_SUSP_I = 3'd7;

  logic [N-1:0] sync1, sync2, prev, hit;
  logic [N-1:0] is_smi, is_alert, is_wake, is_res, is_susp;

  for (genvar i = 0; i < N; i++) begin : g_dec
    logic [AW-1:0] a;
    assign a           = ev_act[i*AW +: AW];
    assign is_smi[i]   = (a == A_SMI) || (a == A_RES_I) || (a == A_SUSP_I);
    assign is_alert[i] = (a == A_ALERT);
    assign is_wake[i]  = (a == A_WAKE);
    assign is_res[i]   = (a == A_RES) || (a == A_RES_I);
    assign is_susp[i]  = (a == A_SUSP) || (a == A_SUSP_I);
  end

  assign hit = ev_en & ((ev_rise & sync2 & ~prev) | (~ev_rise & ~sync2 & prev));

  logic do_res, do_susp;
  assign do_res  = |(hit & is_res) && !wake_dis && !pwr_awake;
  assign do_susp = |(hit & is_susp) && pwr_awake;

  assign smi_evt    = |(ev_status & ev_en & is_smi);
  assign alert_pull = |(ev_status & ev_en & is_alert);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1       <= '0;
      sync2       <= '0;
      prev        <= '0;
      ev_status   <= '0;
      wake_pulse  <= 1'b0;
      resume_req  <= 1'b0;
      suspend_req <= 1'b0;
      pwr_awake   <= 1'b0;
    end else begin
      sync1       <= ev_in;
      sync2       <= sync1;
      prev        <= sync2;
      ev_status   <= (ev_status & ~(clr_wr ? clr_mask : '0)) | hit;
      wake_pulse  <= |(hit & is_wake) && !wake_dis;
      resume_req  <= do_res;
      suspend_req <= do_susp;
      if (do_res)       pwr_awake <= 1'b1;
      else if (do_susp) pwr_awake <= 1'b0;
    end
  end
endmodule

// File: rtl/wake_evt_chk.sv
module wake_evt_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wake_dis,
  input logic         clr_wr,
  input logic [N-1:0] ev_status,
  input logic         alert_pull,
  input logic         wake_pulse,
  input logic         resume_req,
  input logic         suspend_req,
  input logic         pwr_awake
);
  // R5
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(ev_status) & ~ev_status) |-> $past(clr_wr));
  // R6
  alert_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_pull |-> |ev_status);
  // R7
  wake_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !$past(wake_dis));
  // R8
  resume_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> (pwr_awake && !$past(pwr_awake) && !$past(wake_dis)));
  // R9
  suspend_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> (!pwr_awake && $past(pwr_awake)));
  // R10
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resume_req && suspend_req));
  // R10
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resume_req && !suspend_req) |-> $stable(pwr_awake));
endmodule

bind wake_evt_ctrl wake_evt_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_dis(wake_dis), .clr_wr(clr_wr),
  .ev_status(ev_status), .alert_pull(alert_pull), .wake_pulse(wake_pulse),
  .resume_req(resume_req), .suspend_req(suspend_req), .pwr_awake(pwr_awake)
);

// File: tb/tb_wake_evt_ctrl.sv
module tb_wake_evt_ctrl;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] ev_in = '0, ev_en = '0, ev_rise = '0, clr_mask = '0;
  logic [3*N-1:0] ev_act = '0;
  logic wake_dis = 0, clr_wr = 0;
  logic [N-1:0] ev_status;
  logic smi_evt, alert_pull, wake_pulse, resume_req, suspend_req, pwr_awake;

  wake_evt_ctrl #(.N(N)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // reference model (spec: 2-cycle latency, codes per R6)
  logic [N-1:0] h1 = '0, h2 = '0, h3 = '0, m_st = '0;
  bit m_wk = 0, m_rs = 0, m_su = 0, m_aw = 0;

  function automatic logic [2:0] code(int i);
    return ev_act[i*3 +: 3];
  endfunction

  function automatic bit exp_smi();
    for (int i = 0; i < N; i++)
      if (m_st[i] && ev_en[i] && (code(i) inside {3'd1, 3'd6, 3'd7})) return 1;
    return 0;
  endfunction

  function automatic bit exp_alert();
    for (int i = 0; i < N; i++)
      if (m_st[i] && ev_en[i] && code(i) == 3'd2) return 1;
    return 0;
  endfunction

  task automatic model_step();
    logic [N-1:0] h;
    bit w, r, s;
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0; m_st = '0;
      m_wk = 0; m_rs = 0; m_su = 0; m_aw = 0;
      return;
    end
    h = ev_en & ((ev_rise & h2 & ~h3) | (~ev_rise & ~h2 & h3));
    w = 0; r = 0; s = 0;
    for (int i = 0; i < N; i++) if (h[i]) begin
      if (code(i) == 3'd3) w = 1;
      if (code(i) inside {3'd5, 3'd6}) r = 1;
      if (code(i) inside {3'd4, 3'd7}) s = 1;
    end
    m_st = (m_st & ~(clr_wr ? clr_mask : '0)) | h;
    m_wk = w && !wake_dis;
    m_rs = r && !wake_dis && !m_aw;
    m_su = s && m_aw;
    if (m_rs) m_aw = 1; else if (m_su) m_aw = 0;
    h3 = h2; h2 = h1; h1 = ev_in;
  endtask

  task automatic compare_all();
    chk("R5 status", ev_status, m_st);
    chk("R6 smi", smi_evt, exp_smi());
    chk("R6 alert", alert_pull, exp_alert());
    chk("R7 wake", wake_pulse, m_wk);
    chk("R8 resume", resume_req, m_rs);
    chk("R9 suspend", suspend_req, m_su);
    chk("R10 awake", pwr_awake, m_aw);
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    compare_all();
  endtask

  task automatic setup(int i, bit en, bit rise, logic [2:0] a);
    ev_en[i] = en; ev_rise[i] = rise; ev_act[i*3 +: 3] = a;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) tick();
    @(negedge clk) rst_n = 1;
    // R1
    chk("R1 status", ev_status, 0); chk("R1 smi", smi_evt, 0); chk("R1 alert", alert_pull, 0);
    chk("R1 wake", wake_pulse, 0); chk("R1 req", {resume_req, suspend_req}, 0);
    chk("R1 awake", pwr_awake, 0);

    // R2 / R11: rising edge, status-only code
    setup(0, 1, 1, 3'd0); ev_in[0] = 1;
    tick(); tick(); chk("R2 not yet", ev_status[0], 0);
    tick(); chk("R2 latency", ev_status[0], 1);
    chk("R11 no smi", smi_evt, 0); chk("R11 no alert", alert_pull, 0);
    // R5 clear
    clr_wr = 1; clr_mask = 8'h01; tick(); clr_wr = 0;
    chk("R5 cleared", ev_status[0], 0);
    // R3: falling edge ignored with rise polarity
    ev_in[0] = 0; repeat (4) tick(); chk("R3 wrong edge", ev_status[0], 0);
    // R4: disabled input
    setup(1, 0, 1, 3'd3); ev_in[1] = 1;
    repeat (4) begin tick(); chk("R4 no wake", wake_pulse, 0); end
    chk("R4 no status", ev_status[1], 0);
    // R8: resume while suspended
    setup(2, 1, 1, 3'd5); ev_in[2] = 1;
    repeat (3) tick();
    chk("R8 resume strobe", resume_req, 1); chk("R8 awake", pwr_awake, 1);
    tick(); chk("R8 one cycle", resume_req, 0);
    // R10: resume while awake ignored
    ev_in[2] = 0; repeat (3) tick(); ev_in[2] = 1;
    repeat (3) begin tick(); chk("R10 no resume", resume_req, 0); end
    chk("R10 still awake", pwr_awake, 1);
    // R9 + R6: suspend with SMI
    setup(3, 1, 0, 3'd7); ev_in[3] = 1; repeat (3) tick();
    ev_in[3] = 0; repeat (3) tick();
    chk("R9 suspend strobe", suspend_req, 1); chk("R9 asleep", pwr_awake, 0);
    chk("R6 smi", smi_evt, 1);
    // R10: suspend while suspended ignored
    ev_in[3] = 1; repeat (3) tick(); ev_in[3] = 0;
    repeat (3) begin tick(); chk("R10 no suspend", suspend_req, 0); end
    // R7: wake blocked, then allowed
    setup(4, 1, 1, 3'd3); wake_dis = 1; ev_in[4] = 1;
    repeat (3) begin tick(); chk("R7 blocked", wake_pulse, 0); end
    wake_dis = 0; ev_in[4] = 0; repeat (3) tick(); ev_in[4] = 1;
    tick(); tick(); tick(); chk("R7 pulse", wake_pulse, 1);
    tick(); chk("R7 one cycle", wake_pulse, 0);
    // R6: alert
    setup(5, 1, 1, 3'd2); ev_in[5] = 1; repeat (3) tick();
    chk("R6 alert", alert_pull, 1);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      ev_in ^= N'($urandom & $urandom & $urandom);
      if ($urandom % 40 == 0) begin
        ev_en = N'($urandom); ev_rise = N'($urandom); ev_act = (3*N)'($urandom);
      end
      wake_dis = ($urandom % 4 == 0);
      clr_wr = ($urandom % 5 == 0);
      clr_mask = N'($urandom);
      tick();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule